// File: doc/BRIEF.md
# Intra DC Cost Estimator for Luma Macroblocks

This block produces a quick intra-coding cost for one 16x16 luma macroblock, so that a later decision stage can weigh intra against inter coding. The macroblock arrives as a raster-ordered pixel stream. The block holds the whole macroblock, then predicts every 4x4 sub-block with its DC value. It then adds up the absolute differences between the pixels and that prediction, and reports a single sum of absolute differences (SAD).

Neighbouring pixels come from the current frame as it was captured, not from a reconstructed frame. The block keeps two stores for them. The first is a line store that holds the bottom row of every macroblock column. The second is a column store that holds the rightmost column of the macroblock processed last. Both are refreshed at the end of each macroblock. Macroblocks are expected in raster order across the frame, so the column store always holds the left neighbour of the next macroblock in the same row.

The work happens in three phases. A load phase takes the 256 pixels. A prediction phase takes one cycle for each of the 16 sub-blocks. A scan phase takes one cycle for each pixel. The scan starts only after every DC value has been formed.

Top module: `intra_dc_cost`

## Requirements
- R1: After reset, done_o and sad_valid_o are both 0.
- R2: When a sub-block has both an upper and a left neighbour, its DC is (sum of the 4 upper pixels + sum of the 4 left pixels + 4) >> 3.
- R3: When a sub-block has only one neighbour, its DC is (sum of those 4 pixels + 2) >> 2. The upper neighbour exists when the sub-block is not in the top sub-block row or mb_row_i was not 0. The left neighbour exists when the sub-block is not in the left sub-block column or mb_col_i was not 0.
- R4: When a sub-block has no neighbour, its DC is 128.
- R5: A neighbour that lies inside the macroblock is taken from the macroblock's own streamed pixels. Pixel p of the stream sits at row p/16, column p%16.
- R6: A neighbour outside the macroblock comes from the edge stores. The upper neighbour is the bottom row of the last macroblock finished in the same column. The left neighbour is the rightmost column of the last macroblock finished.
- R7: sad_o equals the sum, over all 256 pixels, of |pixel − DC of its sub-block|, in 16 bits with no wrap.
- R8: done_o is a one-cycle pulse. It rises exactly 272 clock edges after the edge that accepts the 256th pixel.
- R9: From done_o onwards, sad_valid_o stays 1 and sad_o stays unchanged until start_i is accepted. Accepting start_i clears sad_valid_o.
- R10: start_i is ignored while a macroblock is in progress. pix_valid_i is ignored outside the load phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a macroblock; accepted only when idle |
| mb_col_i | input | 3 | Macroblock column, sampled with start_i |
| mb_row_i | input | 2 | Macroblock row, sampled with start_i |
| pix_valid_i | input | 1 | pix_i carries a pixel this cycle |
| pix_i | input | 8 | Luma pixel, raster order within the macroblock |
| done_o | output | 1 | One-cycle completion pulse |
| sad_valid_o | output | 1 | sad_o holds a finished result |
| sad_o | output | 16 | Intra DC SAD of the last macroblock |

## Verification
The assertions take for granted that a new start arrives only after the previous done pulse. They also take for granted that reset is held for at least one clock edge, so the result registers start from a known state.

The stimulus waits for each done pulse before it starts the next macroblock. It presents macroblocks in raster order, so the edge stores always hold true neighbours. The one stray start it applies falls inside a load phase, where the block must discard it.

// File: rtl/intra_dc_cost_pkg.sv
package intra_dc_cost_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PRED = 2'd2,
        PH_SCAN = 2'd3
    } phase_e;
endpackage

// File: rtl/idc_dc_unit.sv
module idc_dc_unit #(
    parameter int PIX_W   = 8,
    parameter int SUB_DIM = 4
) (
    input  logic [SUB_DIM-1:0][PIX_W-1:0] top_i,
    input  logic [SUB_DIM-1:0][PIX_W-1:0] left_i,
    input  logic                          top_ok_i,
    input  logic                          left_ok_i,
    output logic [PIX_W-1:0]              dc_o
);
    localparam int SUB_LOG = $clog2(SUB_DIM);
    localparam int SUM_W   = PIX_W + SUB_LOG + 1;

    logic [SUM_W-1:0] sum_top, sum_left, mean;

    always_comb begin
        sum_top  = '0;
        sum_left = '0;
        for (int k = 0; k < SUB_DIM; k++) begin
            sum_top  = sum_top  + SUM_W'(top_i[k]);
            sum_left = sum_left + SUM_W'(left_i[k]);
        end
        unique case ({top_ok_i, left_ok_i})
            2'b11:   mean = (sum_top + sum_left + SUM_W'(SUB_DIM)) >> (SUB_LOG + 1);
            2'b10:   mean = (sum_top + SUM_W'(SUB_DIM / 2)) >> SUB_LOG;
            2'b01:   mean = (sum_left + SUM_W'(SUB_DIM / 2)) >> SUB_LOG;
            default: mean = SUM_W'(1) << (PIX_W - 1);
        endcase
        dc_o = mean[PIX_W-1:0];
    end
endmodule

// File: rtl/idc_absdiff.sv
module idc_absdiff #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] a_i,
    input  logic [PIX_W-1:0] b_i,
    output logic [PIX_W-1:0] d_o
);
    always_comb d_o = (a_i >= b_i) ? (a_i - b_i) : (b_i - a_i);
endmodule

// File: rtl/intra_dc_cost.sv
module intra_dc_cost
    import intra_dc_cost_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int MB_DIM  = 16,
    parameter int SUB_DIM = 4,
    parameter int MB_COLS = 8,
    parameter int MB_ROWS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [$clog2(MB_COLS)-1:0] mb_col_i,
    input  logic [$clog2(MB_ROWS)-1:0] mb_row_i,
    input  logic                       pix_valid_i,
    input  logic [PIX_W-1:0]           pix_i,
    output logic                       done_o,
    output logic                       sad_valid_o,
    output logic [PIX_W+$clog2(MB_DIM*MB_DIM)-1:0] sad_o
);
    localparam int COL_W    = $clog2(MB_COLS);
    localparam int ROW_W    = $clog2(MB_ROWS);
    localparam int MB_PIX   = MB_DIM * MB_DIM;
    localparam int MB_AW    = $clog2(MB_PIX);
    localparam int SPR      = MB_DIM / SUB_DIM;
    localparam int NUM_SUB  = SPR * SPR;
    localparam int NSUB_AW  = $clog2(NUM_SUB);
    localparam int SPR_AW   = $clog2(SPR);
    localparam int LINE_LEN = MB_COLS * MB_DIM;
    localparam int LINE_AW  = $clog2(LINE_LEN);
    localparam int EDGE_AW  = $clog2(MB_DIM);
    localparam int SAD_W    = PIX_W + MB_AW;

    typedef struct packed {
        phase_e           phase;
        logic [MB_AW-1:0] cnt;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [SAD_W-1:0] acc;
        logic             done;
        logic             valid;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [PIX_W-1:0] mb_mem   [MB_PIX];
    logic [PIX_W-1:0] line_mem [LINE_LEN];
    logic [PIX_W-1:0] left_mem [MB_DIM];
    logic [PIX_W-1:0] dc_mem   [NUM_SUB];

    logic                          mb_we, dc_we, edge_we;
    logic [SUB_DIM-1:0][PIX_W-1:0] nb_top, nb_left;
    logic                          top_ok, left_ok;
    logic [PIX_W-1:0]              dc_val;
    logic [SPR_AW-1:0]             bx, by;
    logic [NSUB_AW-1:0]            scan_sub;
    logic [PIX_W-1:0]              scan_pix, scan_dc, scan_diff;

    // neighbour gathering for the sub-block selected by the prediction counter
    always_comb begin
        bx      = st_q.cnt[SPR_AW-1:0];
        by      = st_q.cnt[NSUB_AW-1:SPR_AW];
        top_ok  = (by != '0) || (st_q.row != '0);
        left_ok = (bx != '0) || (st_q.col != '0);
        for (int k = 0; k < SUB_DIM; k++) begin
            if (by == '0)
                nb_top[k] = line_mem[LINE_AW'(int'(st_q.col) * MB_DIM + int'(bx) * SUB_DIM + k)];
            else
                nb_top[k] = mb_mem[MB_AW'((int'(by) * SUB_DIM - 1) * MB_DIM + int'(bx) * SUB_DIM + k)];
            if (bx == '0)
                nb_left[k] = left_mem[EDGE_AW'(int'(by) * SUB_DIM + k)];
            else
                nb_left[k] = mb_mem[MB_AW'((int'(by) * SUB_DIM + k) * MB_DIM + int'(bx) * SUB_DIM - 1)];
        end
    end

    idc_dc_unit #(.PIX_W(PIX_W), .SUB_DIM(SUB_DIM)) u_dc (
        .top_i    (nb_top),
        .left_i   (nb_left),
        .top_ok_i (top_ok),
        .left_ok_i(left_ok),
        .dc_o     (dc_val)
    );

    // scan-phase operand selection
    always_comb begin
        scan_sub = NSUB_AW'(((int'(st_q.cnt) / MB_DIM) / SUB_DIM) * SPR
                            + (int'(st_q.cnt) % MB_DIM) / SUB_DIM);
        scan_pix = mb_mem[st_q.cnt];
        scan_dc  = dc_mem[scan_sub];
    end

    idc_absdiff #(.PIX_W(PIX_W)) u_abs (
        .a_i(scan_pix),
        .b_i(scan_dc),
        .d_o(scan_diff)
    );

    // next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        mb_we     = 1'b0;
        dc_we     = 1'b0;
        edge_we   = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_LOAD;
                    st_d.cnt   = '0;
                    st_d.col   = mb_col_i;
                    st_d.row   = mb_row_i;
                    st_d.acc   = '0;
                    st_d.valid = 1'b0;
                end
            end
            PH_LOAD: begin
                if (pix_valid_i) begin
                    mb_we    = 1'b1;
                    st_d.cnt = st_q.cnt + MB_AW'(1);
                    if (st_q.cnt == MB_AW'(MB_PIX - 1)) begin
                        st_d.phase = PH_PRED;
                        st_d.cnt   = '0;
                    end
                end
            end
            PH_PRED: begin
                dc_we    = 1'b1;
                st_d.cnt = st_q.cnt + MB_AW'(1);
                if (st_q.cnt == MB_AW'(NUM_SUB - 1)) begin
                    st_d.phase = PH_SCAN;
                    st_d.cnt   = '0;
                end
            end
            PH_SCAN: begin
                st_d.acc = st_q.acc + SAD_W'(scan_diff);
                st_d.cnt = st_q.cnt + MB_AW'(1);
                if (st_q.cnt == MB_AW'(MB_PIX - 1)) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.done  = 1'b1;
                    st_d.valid = 1'b1;
                    edge_we    = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (mb_we) mb_mem[st_q.cnt] <= pix_i;
        if (dc_we) dc_mem[st_q.cnt[NSUB_AW-1:0]] <= dc_val;
        if (edge_we) begin
            for (int k = 0; k < MB_DIM; k++) begin
                line_mem[LINE_AW'(int'(st_q.col) * MB_DIM + k)] <= mb_mem[MB_AW'((MB_DIM - 1) * MB_DIM + k)];
                left_mem[EDGE_AW'(k)] <= mb_mem[MB_AW'(k * MB_DIM + MB_DIM - 1)];
            end
        end
    end

    assign done_o      = st_q.done;
    assign sad_valid_o = st_q.valid;
    assign sad_o       = st_q.acc;
endmodule

// File: rtl/intra_dc_cost_chk.sv
module intra_dc_cost_chk
    import intra_dc_cost_pkg::*;
#(
    parameter int SAD_W  = 16,
    parameter int SAD_MAX = 256 * 255
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_o,
    input logic             sad_valid_o,
    input logic [SAD_W-1:0] sad_o,
    input phase_e           phase,
    input logic [SAD_W-1:0] acc
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!done_o && !sad_valid_o));

    // R8
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    a_r8_done_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(phase) == PH_SCAN && phase == PH_IDLE && sad_valid_o));

    // R9
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sad_valid_o && !start_i) |=> (sad_valid_o && $stable(sad_o)));

    // R10
    a_r10_busy_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> !sad_valid_o);

    // R7
    a_r7_acc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SCAN && $past(phase) == PH_SCAN) |-> (acc >= $past(acc)));

    // R7
    a_r7_sad_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid_o |-> (int'(sad_o) <= SAD_MAX));
endmodule

bind intra_dc_cost intra_dc_cost_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .done_o     (done_o),
    .sad_valid_o(sad_valid_o),
    .sad_o      (sad_o),
    .phase      (st_q.phase),
    .acc        (st_q.acc)
);

// File: tb/intra_dc_cost_bench.sv
`timescale 1ns/1ps
module intra_dc_cost_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  mb_col_i = '0;
    logic [1:0]  mb_row_i = '0;
    logic        pix_valid_i = 1'b0;
    logic [7:0]  pix_i = '0;
    logic        done_o, sad_valid_o;
    logic [15:0] sad_o;

    always #2.5 clk = ~clk;

    intra_dc_cost u_intra_dc_cost (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mb_col_i(mb_col_i),
        .mb_row_i(mb_row_i), .pix_valid_i(pix_valid_i), .pix_i(pix_i),
        .done_o(done_o), .sad_valid_o(sad_valid_o), .sad_o(sad_o)
    );

    int    nvec = 0, nfail = 0, cyc = 0;
    bit    checking = 0;
    string cur_tag = "R7";

    int frame [0:63][0:127];
    int m_mode = 0, m_r = 0, m_c = 0, m_n = 0, m_cd = 0, m_exp = 0;
    bit m_done = 0, m_valid = 0;
    int m_sad = 0;

    function automatic int ref_sad(int mr, int mc);
        int s = 0;
        for (int by = 0; by < 4; by++) begin
            for (int bx = 0; bx < 4; bx++) begin
                int gy = mr * 16 + by * 4;
                int gx = mc * 16 + bx * 4;
                int st = 0, sl = 0, dc;
                for (int k = 0; k < 4; k++) begin
                    if (gy > 0) st += frame[gy-1][gx+k];
                    if (gx > 0) sl += frame[gy+k][gx-1];
                end
                if (gy > 0 && gx > 0) dc = (st + sl + 4) >> 3;
                else if (gy > 0)      dc = (st + 2) >> 2;
                else if (gx > 0)      dc = (sl + 2) >> 2;
                else                  dc = 128;
                for (int y = 0; y < 4; y++)
                    for (int x = 0; x < 4; x++) begin
                        int d = frame[gy+y][gx+x] - dc;
                        s += (d < 0) ? -d : d;
                    end
            end
        end
        return s;
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_done = 0; m_valid = 0; m_sad = 0;
        end else begin
            m_done = 0;
            case (m_mode)
                0: if (start_i) begin
                    m_mode = 1; m_r = int'(mb_row_i); m_c = int'(mb_col_i);
                    m_n = 0; m_valid = 0;
                end
                1: if (pix_valid_i) begin
                    frame[m_r*16 + m_n/16][m_c*16 + m_n%16] = int'(pix_i);
                    m_n++;
                    if (m_n == 256) begin
                        m_mode = 2; m_cd = 272; m_exp = ref_sad(m_r, m_c);
                    end
                end
                default: begin
                    m_cd--;
                    if (m_cd == 0) begin
                        m_done = 1; m_valid = 1; m_sad = m_exp; m_mode = 0;
                    end
                end
            endcase
        end
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        if (checking) begin
            nvec++;
            if (done_o !== m_done) begin
                nfail++;
                $display("FAIL R8 done_o actual=%0b expected=%0b", done_o, m_done);
            end
            if (sad_valid_o !== m_valid) begin
                nfail++;
                $display("FAIL R9 sad_valid_o actual=%0b expected=%0b", sad_valid_o, m_valid);
            end
            if (m_valid && int'(sad_o) !== m_sad) begin
                nfail++;
                $display("FAIL %s sad_o actual=%0d expected=%0d", cur_tag, sad_o, m_sad);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d cycles expected=done", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    function automatic logic [7:0] gen_pix(int kind, int r, int c, int seed);
        int v;
        case (kind)
            0: v = (r * 37 + c * 91 + seed * 53 + ((r * c) ^ (seed * 7))) % 256;
            1: v = 200;
            2: v = (((r + c) % 2) == 0) ? 0 : 255;
            default: v = (r * 15 + c * 3 + seed) % 256;
        endcase
        return 8'(v);
    endfunction

    task automatic send_mb(int mr, int mc, int kind, int seed, bit stray);
        @(negedge clk);
        start_i = 1'b1; mb_row_i = 2'(mr); mb_col_i = 3'(mc);
        @(negedge clk);
        start_i = 1'b0;
        for (int p = 0; p < 256; p++) begin
            if (stray && (p % 5 == 2)) begin
                pix_valid_i = 1'b0; pix_i = 8'hAA;
                @(negedge clk);
            end
            // R10: a start during the load phase, carrying another position
            if (stray && p == 100) begin
                start_i = 1'b1; mb_row_i = 2'd3; mb_col_i = 3'd7;
            end
            pix_valid_i = 1'b1;
            pix_i = gen_pix(kind, p / 16, p % 16, seed);
            @(negedge clk);
            start_i = 1'b0;
        end
        pix_valid_i = 1'b0;
        if (stray) begin
            // R10: pixels offered during prediction must be discarded
            for (int g = 0; g < 12; g++) begin
                pix_valid_i = 1'b1; pix_i = 8'(g * 19);
                @(negedge clk);
            end
            pix_valid_i = 1'b0;
        end
        repeat (290) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        nvec++;
        if (done_o !== 1'b0 || sad_valid_o !== 1'b0) begin
            nfail++;
            $display("FAIL R1 reset outputs actual=%0b%0b expected=00", done_o, sad_valid_o);
        end
        checking = 1;
        cur_tag = "R3 R4 R5";  send_mb(0, 0, 0, 1, 0);
        cur_tag = "R2 R6";     send_mb(0, 1, 3, 4, 0);
        cur_tag = "R2 R6";     send_mb(0, 2, 1, 0, 0);
        cur_tag = "R3 R6";     send_mb(1, 0, 0, 9, 0);
        cur_tag = "R10";       send_mb(1, 1, 0, 5, 1);
        cur_tag = "R7";        send_mb(1, 2, 2, 0, 0);
        cur_tag = "R9";
        repeat (30) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule